// File: doc/BRIEF.md
# Indexed Socket Register Port

This block is the host-facing register front end of a card interface controller that looks after a parameterised number of card sockets (two by default). The host sees only two byte-wide locations: an index location at the even address and a data location at the odd address next to it. The host first writes an index byte and then moves data through the data location. The upper two bits of the index pick the socket and the lower six bits pick one of 64 register offsets inside that socket's bank.

Each socket bank holds three registers. The first is a read-only identification byte. The second is a power control register with output enable, reset-drive disable, automatic switching enable and two supply select fields. The third is a window enable register with enables for five memory windows and two I/O windows. All other offsets read as zero, and writes to them have no effect. When an index names a socket that this controller does not serve, the data location makes no access and leaves the bus undriven.

Reads are combinational from the stored state, so read data is valid in the same cycle as the read strobe. Writes take effect on the rising clock edge while the strobe is high.

Top module: `sock_port`

## Requirements
- R1: A write to the index location (addr_i=0) stores wdata_i in the index register. A read of the index location returns the stored byte with rdata_oe_o high.
- R2: The index register keeps its value across any number of data-location accesses. It changes only on a write to the index location.
- R3: Index bits [7:6] select the socket and bits [5:0] select the register offset. A data write to one socket does not change any register of another socket.
- R4: Offset 0x00 reads 0x82 when REVISION=0 and 0x83 when REVISION=1. Writes to it are ignored.
- R5: Offset 0x02 is the power register. Bit 7 is output enable, bit 6 is reset-drive disable, bit 5 is auto switch enable, bits [4:3] are the Vcc select and bits [1:0] are the Vpp select. Bit 2 cannot be written and reads 0.
- R6: Offset 0x06 is the window enable register. Bits [4:0] enable memory windows 0 to 4, with bit 0 for window 0. Bits 6 and 7 enable I/O windows 0 and 1. Bit 5 cannot be written and reads 0.
- R7: Every offset other than 0x00, 0x02 and 0x06 reads 0x00, and writes to it are ignored.
- R8: A data access whose socket field is NUM_SOCKETS or higher reads with rdata_oe_o low and writes nothing.
- R9: Asserting rst_ni low clears the index register and every writable register to zero.
- R10: rdata_o is 0x00 whenever rdata_oe_o is low. rdata_oe_o is high only during a read of the index location, or during a read of the data location with a valid socket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Host chip select for the location pair |
| addr_i | input | 1 | 0 = index location, 1 = data location |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| rdata_oe_o | output | 1 | Read data drive enable |

## Verification
A corrupted index register appears at once on the next index read. It also sends every later data access to the wrong socket or offset, and the following data read returns another register's value. A bank register that takes a stray write, or drops a field bit, shows the wrong byte on the first read of that offset. A socket decode fault shows up as a change seen through the other socket, or as the drive enable being raised for a socket that does not exist. Every such fault is visible within one read cycle of the access that caused it.

// File: rtl/sock_port_pkg.sv
package sock_port_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFF_W  = 6;
  localparam int unsigned SOCK_W = BYTE_W - OFF_W;

  localparam logic [OFF_W-1:0] OFF_ID  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_PWR = 6'h02;
  localparam logic [OFF_W-1:0] OFF_WIN = 6'h06;

  localparam logic [BYTE_W-1:0] ID_BASE  = 8'h82;
  localparam logic [BYTE_W-1:0] PWR_MASK = 8'hFB;
  localparam logic [BYTE_W-1:0] WIN_MASK = 8'hDF;

  typedef struct packed {
    logic [SOCK_W-1:0] sock;
    logic [OFF_W-1:0]  off;
  } index_t;
endpackage

// File: rtl/sock_index_reg.sv
module sock_index_reg
  import sock_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output index_t            idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_o <= '0;
    else if (we_i) idx_o <= index_t'(wdata_i);
  end
endmodule

// File: rtl/sock_bank.sv
module sock_bank
  import sock_port_pkg::*;
#(
  parameter int unsigned REVISION = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam logic [BYTE_W-1:0] ID_VAL = ID_BASE + BYTE_W'(REVISION);

  logic [BYTE_W-1:0] pwr_q, win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= '0;
      win_q <= '0;
    end else if (we_i) begin
      if (off_i == OFF_PWR) pwr_q <= wdata_i & PWR_MASK;
      if (off_i == OFF_WIN) win_q <= wdata_i & WIN_MASK;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_ID:  rdata_o = ID_VAL;
      OFF_PWR: rdata_o = pwr_q;
      OFF_WIN: rdata_o = win_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sock_port.sv
module sock_port
  import sock_port_pkg::*;
#(
  parameter int unsigned NUM_SOCKETS = 2,
  parameter int unsigned REVISION    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  index_t idx_q;
  logic   idx_we, data_wr, data_rd, sock_ok;
  logic [BYTE_W-1:0] bank_rdata [NUM_SOCKETS];
  logic [BYTE_W-1:0] data_rdata;

  assign idx_we  = sel_i && wr_i && !addr_i;
  assign data_wr = sel_i && wr_i && addr_i;
  assign data_rd = sel_i && rd_i && addr_i;
  assign sock_ok = 32'(idx_q.sock) < NUM_SOCKETS;

  sock_index_reg u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (idx_we),
    .wdata_i (wdata_i),
    .idx_o   (idx_q)
  );

  for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_bank
    logic bank_we;
    assign bank_we = data_wr && sock_ok && (32'(idx_q.sock) == s);
    sock_bank #(.REVISION(REVISION)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .off_i   (idx_q.off),
      .wdata_i (wdata_i),
      .rdata_o (bank_rdata[s])
    );
  end

  always_comb begin
    data_rdata = '0;
    for (int s = 0; s < NUM_SOCKETS; s++)
      if (32'(idx_q.sock) == s) data_rdata = bank_rdata[s];
  end

  always_comb begin
    rdata_oe_o = 1'b0;
    rdata_o    = '0;
    if (sel_i && rd_i && !addr_i) begin
      rdata_oe_o = 1'b1;
      rdata_o    = idx_q;
    end else if (data_rd && sock_ok) begin
      rdata_oe_o = 1'b1;
      rdata_o    = data_rdata;
    end
  end
endmodule

// File: rtl/sock_port_chk.sv
module sock_port_chk
  import sock_port_pkg::*;
#(
  parameter int unsigned NUM_SOCKETS = 2,
  parameter int unsigned REVISION    = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input index_t            idx_q
);
  logic dread, bad_sock;
  assign dread    = sel_i && rd_i && addr_i;
  assign bad_sock = 32'(idx_q.sock) >= NUM_SOCKETS;

  a_r1_idx_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && !addr_i) |-> (rdata_oe_o && rdata_o == idx_q));

  a_r2_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i && !addr_i) |=> $stable(idx_q));

  a_r4_id_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread && !bad_sock && idx_q.off == OFF_ID) |-> (rdata_o == ID_BASE + BYTE_W'(REVISION)));

  a_r5_pwr_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread && idx_q.off == OFF_PWR) |-> !rdata_o[2]);

  a_r6_win_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread && idx_q.off == OFF_WIN) |-> !rdata_o[5]);

  a_r7_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread && idx_q.off != OFF_ID && idx_q.off != OFF_PWR && idx_q.off != OFF_WIN)
      |-> (rdata_o == '0));

  a_r8_bad_sock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dread && bad_sock) |-> !rdata_oe_o);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0));
endmodule

bind sock_port sock_port_chk #(.NUM_SOCKETS(NUM_SOCKETS), .REVISION(REVISION)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .idx_q      (idx_q)
);

// File: tb/tb_sock_port.sv
module tb_sock_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rdata_oe_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  sock_port dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rdata_oe_o (rdata_oe_o)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; addr_i = a; wr_i = 1; wdata_i = d;
    @(posedge clk_i); #1;
    sel_i = 0; wr_i = 0; wdata_i = '0;
  endtask

  // returns {oe, data}
  task automatic rd(logic a, output logic [8:0] r);
    @(negedge clk_i);
    sel_i = 1; addr_i = a; rd_i = 1;
    #1 r = {rdata_oe_o, rdata_o};
    @(posedge clk_i); #1;
    sel_i = 0; rd_i = 0;
  endtask

  task automatic rd_reg(logic [7:0] idx, output logic [8:0] r);
    wr(0, idx);
    rd(1, r);
  endtask

  task automatic wr_reg(logic [7:0] idx, logic [7:0] d);
    wr(0, idx);
    wr(1, d);
  endtask

  task automatic t_reset;
    logic [8:0] r;
    rd(0, r);           check("R9 index", r, {1'b1, 8'h00});
    rd_reg(8'h02, r);   check("R9 pwr s0", r, {1'b1, 8'h00});
    rd_reg(8'h46, r);   check("R9 win s1", r, {1'b1, 8'h00});
    @(negedge clk_i); #1;
    check("R10 idle", {rdata_oe_o, rdata_o}, 9'h000);
  endtask

  task automatic t_index;
    logic [8:0] r;
    wr(0, 8'hA5); rd(0, r); check("R1 index A5", r, {1'b1, 8'hA5});
    wr(0, 8'h02); wr(1, 8'hF8);
    wr(1, 8'hF9); rd(1, r); check("R2 repeat data", r, {1'b1, 8'hF9});
    rd(0, r); check("R2 index held", r, {1'b1, 8'h02});
  endtask

  task automatic t_id;
    logic [8:0] r;
    rd_reg(8'h00, r); check("R4 id s0", r, {1'b1, 8'h82});
    wr(1, 8'h11); rd(1, r); check("R4 id write ignored", r, {1'b1, 8'h82});
    rd_reg(8'h40, r); check("R4 id s1", r, {1'b1, 8'h82});
  endtask

  task automatic t_fields;
    logic [8:0] r;
    wr_reg(8'h02, 8'hFF); rd(1, r); check("R5 pwr all", r, {1'b1, 8'hFB});
    wr(1, 8'h99); rd(1, r); check("R5 pwr 99", r, {1'b1, 8'h99});
    wr(1, 8'h04); rd(1, r); check("R5 bit2 only", r, {1'b1, 8'h00});
    wr_reg(8'h06, 8'hFF); rd(1, r); check("R6 win all", r, {1'b1, 8'hDF});
    wr(1, 8'h41); rd(1, r); check("R6 win 41", r, {1'b1, 8'h41});
  endtask

  task automatic t_sockets;
    logic [8:0] r;
    wr_reg(8'h46, 8'h9E);
    rd_reg(8'h06, r); check("R3 s0 untouched", r, {1'b1, 8'h41});
    rd_reg(8'h46, r); check("R3 s1 win", r, {1'b1, 8'h9E});
    wr_reg(8'h42, 8'h23);
    rd_reg(8'h02, r); check("R3 s0 pwr kept", r, {1'b1, 8'h00});
    rd_reg(8'h42, r); check("R3 s1 pwr", r, {1'b1, 8'h23});
  endtask

  task automatic t_unimpl;
    logic [8:0] r;
    wr_reg(8'h07, 8'hFF); rd(1, r); check("R7 off07", r, {1'b1, 8'h00});
    wr_reg(8'h3F, 8'h5A); rd(1, r); check("R7 off3F", r, {1'b1, 8'h00});
    rd_reg(8'h06, r); check("R7 neighbour kept", r, {1'b1, 8'h41});
  endtask

  task automatic t_badsock;
    logic [8:0] r;
    rd_reg(8'h86, r); check("R8 sock2 no drive", r, 9'h000);
    wr(1, 8'hFF);
    rd_reg(8'hC2, r); check("R8 sock3 no drive", r, 9'h000);
    wr(1, 8'hFF);
    rd_reg(8'h06, r); check("R8 s0 win kept", r, {1'b1, 8'h41});
    rd_reg(8'h42, r); check("R8 s1 pwr kept", r, {1'b1, 8'h23});
  endtask

  task automatic t_rereset;
    logic [8:0] r;
    wr(0, 8'h46);
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    rd(0, r); check("R9 index cleared", r, {1'b1, 8'h00});
    rd_reg(8'h46, r); check("R9 s1 win cleared", r, {1'b1, 8'h00});
    rd_reg(8'h02, r); check("R9 s0 pwr cleared", r, {1'b1, 8'h00});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset;
    t_index;
    t_id;
    t_fields;
    t_sockets;
    t_unimpl;
    t_badsock;
    t_rereset;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule